// File: doc/BRIEF.md
# Dual Shift-Register Chip Write Serializer

This block turns a parallel register write (a 4-bit register address and an 8-bit value) into the pin sequence that loads two cascaded 8-bit serial-in/parallel-out latch registers. It then commits the write to the sound chip behind them. A request is accepted on a valid/ready handshake. The block then emits 16 serial bits with a bit clock: the data byte first, then the address byte. Next it gives one pulse on the storage-latch clock, and finally holds an active-low write strobe for a minimum time so that the slow sound chip can sample the parallel bus.

The frame layout is fixed, and two board variants differ only in the order of the low five data bits. The parameter `ORDER_SEL` picks the variant at build time. The serial-clock phase length and the strobe hold time are parameters. The default hold is derived from the system clock frequency so that the strobe lasts at least 1 µs.

Top module: `sr_write_serializer`

## Requirements
- R1: While `rst_ni` is low and after its release, the block is idle. In that state `sclk_o`, `sdata_o` and `lclk_o` are 0, and `wr_no` and `req_ready_o` are 1.
- R2: An accepted request produces exactly 16 rising edges on `sclk_o`. `sclk_o` is low before the first edge. `sdata_o` does not change while `sclk_o` is high.
- R3: With `ORDER_SEL=0`, the bit sampled at rising edge k (k=0..15) is data bits 0,1,2,3,4 for k=0..4 and data bit 7 for k=5..7. For k=8..11 it is address bits 3,2,1,0. For k=12..15 it is 0, because the address byte is the 4-bit address zero-extended, so its bit 7 is 0.
- R4: With `ORDER_SEL=1`, edges k=0..4 carry data bits 4,3,2,1,0. Edges 5..15 carry the same bits as in R3.
- R5: Data bits 5 and 6 never reach the serial line; changing them alone leaves the frame unchanged.
- R6: After the 16th bit, `lclk_o` gives exactly one pulse. It rises while `sclk_o` is low and only after all 16 bits. It falls in the same cycle in which `wr_no` falls, and from then on `sdata_o` is 0.
- R7: `wr_no` goes low only in the cycle after `lclk_o` was high. It then stays low for exactly `HOLD_CYCLES` clocks (default ceil(`CLK_HZ` × `HOLD_NS` / 1e9), which is 100 clocks = 1 µs at 100 MHz), and returns high once per request.
- R8: `req_ready_o` falls in the cycle after a request is accepted. It stays low until `wr_no` returns high, and rises in that same cycle. The busy time is 33 × `HALF_CYCLES` + `HOLD_CYCLES` clocks.
- R9: `req_valid_i`, `req_addr_i` and `req_data_i` are ignored while `req_ready_o` is low.
- R10: Every high phase and every low phase of `sclk_o` lasts exactly `HALF_CYCLES` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 4 | Sound-chip register address |
| req_data_i | input | 8 | Value to write |
| sclk_o | output | 1 | Shift clock to the latch registers |
| sdata_o | output | 1 | Serial data to the latch registers |
| lclk_o | output | 1 | Storage-latch clock |
| wr_no | output | 1 | Active-low write strobe to the sound chip |

## Verification
The bench models the two chained latch registers and captures the 16 bits on the shift-clock edges. It compares the latched frame against a frame built from R3 and R4. Bits 7, 6 and 5 of the data are set in different combinations, so that a design which swapped the padding source, or which leaked bits 5 and 6, would latch a wrong pattern. Requests are held valid with different contents during a busy period. This exposes a design that restarts or re-captures mid-frame: it would show a wrong frame, extra latch pulses or a longer busy time. A reset issued in the middle of a shift must return every pin to idle at once. The strobe width and the total busy time are counted in clocks, which catches a hold counter or a phase counter that is off by one.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned FRAME_W  = 2 * DATA_W;
  localparam int unsigned LOW_BITS = 5;
  localparam int unsigned IDX_W    = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LO    = 3'd1,
    S_HI    = 3'd2,
    S_LATCH = 3'd3,
    S_HOLD  = 3'd4
  } srw_state_e;
endpackage

// File: rtl/srw_frame_map.sv
module srw_frame_map
  import srw_pkg::*;
#(
  parameter bit ORDER_SEL = 1'b0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] slots_o   // slots_o[k] goes out at shift edge k
);
  localparam int unsigned PAD_D = DATA_W - LOW_BITS;
  localparam int unsigned PAD_A = DATA_W - ADDR_W;

  logic unused_mid_bits;
  assign unused_mid_bits = ^data_i[DATA_W-2:LOW_BITS];

  if (ORDER_SEL == 1'b0) begin : g_lsb_first
    for (genvar i = 0; i < LOW_BITS; i++) begin : g_d
      assign slots_o[i] = data_i[i];
    end
  end else begin : g_msb_first
    for (genvar i = 0; i < LOW_BITS; i++) begin : g_d
      assign slots_o[i] = data_i[LOW_BITS-1-i];
    end
  end

  for (genvar i = 0; i < PAD_D; i++) begin : g_dpad
    assign slots_o[LOW_BITS+i] = data_i[DATA_W-1];
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_a
    assign slots_o[DATA_W+i] = addr_i[ADDR_W-1-i];
  end

  // address byte is zero-extended, so its top bit is always 0
  for (genvar i = 0; i < PAD_A; i++) begin : g_apad
    assign slots_o[DATA_W+ADDR_W+i] = 1'b0;
  end
endmodule

// File: rtl/srw_phase_timer.sv
module srw_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/srw_seq.sv
module srw_seq
  import srw_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 2,
  parameter int unsigned HOLD_CYCLES = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [FRAME_W-1:0] slots_i,
  output logic               ready_o,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               lclk_o,
  output logic               wr_no
);
  localparam int unsigned MAX_LEN = (HOLD_CYCLES > HALF_CYCLES) ? HOLD_CYCLES : HALF_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  srw_state_e         st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               ld;
  logic [CNT_W-1:0]   ld_val;
  logic               tmr_done;

  srw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .done_o     (tmr_done)
  );

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    frame_d = frame_q;
    ld      = 1'b0;
    ld_val  = HALF_LD;
    unique case (st_q)
      S_IDLE: if (valid_i) begin
        st_d    = S_LO;
        idx_d   = '0;
        frame_d = slots_i;
        ld      = 1'b1;
      end
      S_LO: if (tmr_done) begin
        st_d = S_HI;
        ld   = 1'b1;
      end
      S_HI: if (tmr_done) begin
        ld = 1'b1;
        if (idx_q == LAST_IDX) begin
          st_d = S_LATCH;
        end else begin
          st_d  = S_LO;
          idx_d = idx_q + 1'b1;
        end
      end
      S_LATCH: if (tmr_done) begin
        st_d   = S_HOLD;
        ld     = 1'b1;
        ld_val = HOLD_LD;
      end
      S_HOLD: if (tmr_done) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // outputs registered from next state: no decode glitches on board pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      frame_q <= '0;
      ready_o <= 1'b1;
      sclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      lclk_o  <= 1'b0;
      wr_no   <= 1'b1;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      frame_q <= frame_d;
      ready_o <= (st_d == S_IDLE);
      sclk_o  <= (st_d == S_HI);
      sdata_o <= ((st_d == S_LO) || (st_d == S_HI)) ? frame_d[idx_d] : 1'b0;
      lclk_o  <= (st_d == S_LATCH);
      wr_no   <= (st_d != S_HOLD);
    end
  end
endmodule

// File: rtl/sr_write_serializer.sv
module sr_write_serializer
  import srw_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned HALF_CYCLES = 2,
  parameter int unsigned HOLD_NS     = 1000,
  parameter int unsigned HOLD_CYCLES = (CLK_HZ / 1000 * HOLD_NS + 999_999) / 1_000_000,
  parameter bit          ORDER_SEL   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              lclk_o,
  output logic              wr_no
);
  logic [FRAME_W-1:0] slots;

  srw_frame_map #(.ORDER_SEL(ORDER_SEL)) u_map (
    .addr_i  (req_addr_i),
    .data_i  (req_data_i),
    .slots_o (slots)
  );

  srw_seq #(
    .HALF_CYCLES (HALF_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .slots_i (slots),
    .ready_o (req_ready_o),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .lclk_o  (lclk_o),
    .wr_no   (wr_no)
  );
endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
  parameter int unsigned HOLD_CYCLES = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic lclk_o,
  input logic wr_no
);
  int unsigned rise_cnt;
  int unsigned low_cnt;
  logic        sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt <= 0;
      low_cnt  <= 0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      if (req_valid_i && req_ready_o) rise_cnt <= 0;
      else if (sclk_o && !sclk_q)     rise_cnt <= rise_cnt + 1;
      low_cnt <= wr_no ? 0 : low_cnt + 1;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (wr_no && !sclk_o && !lclk_o)); // R1
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R2
  AST_RISE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && !sclk_q) |-> (rise_cnt < 16)); // R2
  AST_LATCH_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lclk_o) |-> (rise_cnt == 16 && !sclk_o)); // R6
  AST_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (!sdata_o && !lclk_o && !sclk_o)); // R6
  AST_STROBE_AFTER_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> $past(lclk_o)); // R7
  AST_HOLD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (low_cnt == HOLD_CYCLES)); // R7
  AST_BUSY_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> !req_ready_o); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R8
endmodule

bind sr_write_serializer srw_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_srw_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .sclk_o      (sclk_o),
  .sdata_o     (sdata_o),
  .lclk_o      (lclk_o),
  .wr_no       (wr_no)
);

// File: tb/srw_bus_model.sv
module srw_bus_model #(
  parameter int HALF = 2
) (
  input  logic        clk_i,
  input  logic        clr_i,
  input  logic        sclk_i,
  input  logic        sdata_i,
  input  logic        lclk_i,
  input  logic        wr_ni,
  output logic [15:0] latched_o,
  output int          rises_o,
  output int          latches_o,
  output int          wr_pulses_o,
  output int          wr_width_o,
  output int          bad_o
);
  logic [15:0] chain;
  logic        sclk_p = 1'b0, sdata_p = 1'b0, lclk_p = 1'b0, wr_p = 1'b1;
  int          hi_w, lo_w, wr_w;

  always @(posedge clk_i) begin
    sclk_p  <= sclk_i;
    sdata_p <= sdata_i;
    lclk_p  <= lclk_i;
    wr_p    <= wr_ni;
    if (clr_i) begin
      chain <= '0; latched_o <= '0; rises_o <= 0; latches_o <= 0;
      wr_pulses_o <= 0; wr_width_o <= 0; bad_o <= 0;
      hi_w <= 0; lo_w <= 0; wr_w <= 0;
    end else begin
      if (sclk_i && !sclk_p) begin
        chain   <= {chain[14:0], sdata_i};
        rises_o <= rises_o + 1;
        if (lo_w != HALF) bad_o <= bad_o + 1;   // low phase before each edge
      end
      if (sclk_i && sclk_p && (sdata_i != sdata_p)) bad_o <= bad_o + 1;
      hi_w <= sclk_i ? hi_w + 1 : 0;
      lo_w <= (!sclk_i && wr_ni && !lclk_i) ? lo_w + 1 : 0;
      if (!sclk_i && sclk_p && (hi_w != HALF)) bad_o <= bad_o + 1;
      if (lclk_i && !lclk_p) begin
        latched_o <= chain;
        latches_o <= latches_o + 1;
        if (sclk_i) bad_o <= bad_o + 1;
      end
      if (!wr_ni && wr_p && !lclk_p) bad_o <= bad_o + 1;
      if (!wr_ni && (sdata_i || lclk_i)) bad_o <= bad_o + 1;
      wr_w <= wr_ni ? 0 : wr_w + 1;
      if (wr_ni && !wr_p) begin
        wr_pulses_o <= wr_pulses_o + 1;
        wr_width_o  <= wr_w;
      end
    end
  end
endmodule

// File: tb/tb_sr_write_serializer.sv
`timescale 1ns/1ps
module tb_sr_write_serializer;
  localparam int HALF = 2;
  localparam int HOLD = 100;            // 1 us at 100 MHz
  localparam int LAT  = 33 * HALF + HOLD;
  localparam int NV   = 8;
  // {addr[3:0], data[7:0]}
  localparam logic [11:0] VECS [NV] = '{
    12'h000, 12'hFFF, 12'hA15, 12'h50A, 12'h380, 12'hC60, 12'h91F, 12'h6E1
  };

  logic       clk = 1'b0, rst_n = 1'b0, valid = 1'b0, clr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] data = '0;
  logic       ready, sclk, sdata, lclk, wr_n;
  logic       ready_b, sclk_b, sdata_b, lclk_b, wr_n_b;
  logic [15:0] lat_a, lat_b;
  int rises_a, latches_a, pulses_a, width_a, bad_a;
  int rises_b, latches_b, pulses_b, width_b, bad_b;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  sr_write_serializer #(.HALF_CYCLES(HALF), .ORDER_SEL(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_addr_i(addr), .req_data_i(data),
    .sclk_o(sclk), .sdata_o(sdata), .lclk_o(lclk), .wr_no(wr_n));

  sr_write_serializer #(.HALF_CYCLES(HALF), .ORDER_SEL(1'b1)) dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready_b),
    .req_addr_i(addr), .req_data_i(data),
    .sclk_o(sclk_b), .sdata_o(sdata_b), .lclk_o(lclk_b), .wr_no(wr_n_b));

  srw_bus_model #(.HALF(HALF)) mdl_a (
    .clk_i(clk), .clr_i(clr), .sclk_i(sclk), .sdata_i(sdata), .lclk_i(lclk), .wr_ni(wr_n),
    .latched_o(lat_a), .rises_o(rises_a), .latches_o(latches_a),
    .wr_pulses_o(pulses_a), .wr_width_o(width_a), .bad_o(bad_a));

  srw_bus_model #(.HALF(HALF)) mdl_b (
    .clk_i(clk), .clr_i(clr), .sclk_i(sclk_b), .sdata_i(sdata_b), .lclk_i(lclk_b), .wr_ni(wr_n_b),
    .latched_o(lat_b), .rises_o(rises_b), .latches_o(latches_b),
    .wr_pulses_o(pulses_b), .wr_width_o(width_b), .bad_o(bad_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // chain order: the bit from edge k ends at position 15-k
  function automatic logic [15:0] exp_chain(input bit alt, input logic [3:0] a, input logic [7:0] d);
    logic [15:0] s;
    for (int i = 0; i < 5; i++) s[i] = alt ? d[4-i] : d[i];
    for (int i = 5; i < 8; i++) s[i] = d[7];
    for (int i = 0; i < 4; i++) s[8+i] = a[3-i];
    for (int i = 12; i < 16; i++) s[i] = 1'b0;
    for (int k = 0; k < 16; k++) exp_chain[15-k] = s[k];
  endfunction

  task automatic check_idle(input string tag);
    chk(ready && !sclk && !sdata && !lclk && wr_n, tag,
        {ready, sclk, sdata, lclk, wr_n}, 5'b10001);
  endtask

  // one request; junk>0 keeps valid high with other contents for junk busy cycles (R9)
  task automatic run(input logic [3:0] a, input logic [7:0] d, input int junk);
    int busy = 0;
    @(negedge clk);
    clr = 1'b1; valid = 1'b1; addr = a; data = d;
    @(negedge clk);
    clr = 1'b0;
    while (!ready && busy < LAT + 50) begin
      if (busy < junk) begin valid = 1'b1; addr = ~a; data = ~d; end
      else valid = 1'b0;
      busy++;
      @(negedge clk);
    end
    valid = 1'b0;
    chk(wr_n, "R8 strobe high when ready returns", wr_n, 1);
    repeat (3) @(negedge clk);
    chk(busy == LAT, "R8 busy length", busy, LAT);
    chk(lat_a == exp_chain(1'b0, a, d), "R3 default frame", lat_a, exp_chain(1'b0, a, d));
    chk(lat_b == exp_chain(1'b1, a, d), "R4 alternate frame", lat_b, exp_chain(1'b1, a, d));
    chk(rises_a == 16 && rises_b == 16, "R2 shift edge count", rises_a, 16);
    chk(latches_a == 1 && latches_b == 1, "R6 latch pulse count", latches_a, 1);
    chk(pulses_a == 1 && width_a == HOLD, "R7 strobe width", width_a, HOLD);
    chk(width_b == HOLD, "R7 strobe width alt", width_b, HOLD);
    chk(bad_a == 0 && bad_b == 0, "R10 R6 pin ordering and phase widths", bad_a + bad_b, 0);
    check_idle("R1 idle after request");
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 after reset release");

    for (int v = 0; v < NV; v++) run(VECS[v][11:8], VECS[v][7:0], 0);

    // R5: only bits 5/6 differ from an earlier vector, frames must match
    run(4'hA, 8'h75, 0);
    chk(lat_a == exp_chain(1'b0, 4'hA, 8'h15), "R5 bits 5 and 6 dropped", lat_a, exp_chain(1'b0, 4'hA, 8'h15));

    // R9: new requests held valid during the busy window
    run(4'h7, 8'h93, 60);
    run(4'h2, 8'h4C, LAT - 1);

    // R1: reset in the middle of shifting returns pins to idle at once
    @(negedge clk);
    valid = 1'b1; addr = 4'h5; data = 8'hFF;
    @(negedge clk);
    valid = 1'b0;
    repeat (21) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R1 reset mid-frame");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after mid-frame reset");
    run(4'hE, 8'h8B, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule